// File: doc/BRIEF.md
# Double-Buffered Four-Channel DMA Engine

This block moves data from memory to memory on four independent channels. Each channel holds two register sets. Software writes the programming set, which holds a source address, a destination address and a word count. The datapath works only from the active set. An enable command on an idle channel copies the programming set into the active set and starts the channel. An enable command on a busy channel only marks the programming set as queued. When the running transfer ends, the queued set becomes active at once, so two transfers run back to back without the channel going idle.

A single scheduler visits the channels in turn. On each visit a running channel either finishes its transfer or moves one burst of at most `BURST_WORDS` 32-bit words, one word per clock. It then gives up the slot to the next channel. Each channel has its own sticky bits for completion, error and rejected setup.

Two test aids are built in. A fault counter aborts the channel on a chosen visit. A skip flag hides the next completion interrupt.

Top module: `dbdma_ctrl`

## Requirements
- R1: After reset, every bit of `stat_run`, `stat_pend`, `stat_done`, `stat_err` and `stat_reject` is 0, and `irq` and `mem_wr_en` are low.
- R2: An enable command (`cmd_op` = 0) on a channel whose run bit is 0 loads the programming set into the active set. The run bit reads 1 and the pending bit reads 0 one cycle after the command.
- R3: An enable command on a running channel sets its pending bit one cycle later and does not disturb the running transfer. The pending bit is never 1 while the run bit is 0.
- R4: When a channel with its pending bit set reaches the end of its active transfer, the queued set is loaded and the pending bit clears while the run bit stays 1. Both transfers land in full in memory.
- R5: When a channel with no pending set reaches the end of its transfer, its run bit clears and its done bit sets. `irq` is the OR of all done and error bits. A done bit rises only on a channel that was running.
- R6: A skip command (`cmd_op` = 3) with argument 1 on an idle channel suppresses exactly the next completion, and the following completion sets done as usual. A skip argument greater than 1 is refused and sets the reject bit.
- R7: A fault command (`cmd_op` = 2) or skip command sent while the channel runs is ignored and sets the channel's reject bit one cycle later.
- R8: A stop command (`cmd_op` = 1) clears the run and pending bits one cycle later. No further memory writes are made for that channel, and done is not set.
- R9: A fault count of N aborts the channel on its Nth visit while running. The error bit sets, run and pending clear, and only the bursts moved on earlier visits reach memory.
- R10: One word is copied per clock in bursts of at most `BURST_WORDS` consecutive writes. Channels are served round-robin, so two running channels interleave their bursts.
- R11: A clear command (`cmd_op` = 4) clears the channel's done, error and reject bits one cycle later.
- R12: A transfer with a count of 0 completes on its first visit with no memory write. The programming set is captured from `prog_*` when `prog_we` is high, for the channel given by `prog_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_we | input | 1 | Write the programming set of channel `prog_ch` |
| prog_ch | input | CH_W | Channel whose programming set is written |
| prog_src | input | AW | Source byte address, word aligned |
| prog_dst | input | AW | Destination byte address, word aligned |
| prog_cnt | input | CNT_W | Transfer length in 32-bit words |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 enable, 1 stop, 2 set fault count, 3 set skip, 4 clear status |
| cmd_ch | input | CH_W | Channel the command applies to |
| cmd_arg | input | FAIL_W | Fault count or skip value |
| mem_rd_addr | output | AW | Read address, same-cycle read data expected |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Write strobe, one word per cycle |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 32 | Write data |
| stat_run | output | NCH | Run bit per channel |
| stat_pend | output | NCH | Queued-set pending bit per channel |
| stat_done | output | NCH | Sticky completion bit per channel |
| stat_err | output | NCH | Sticky abort bit per channel |
| stat_reject | output | NCH | Sticky refused-setup bit per channel |
| irq | output | 1 | OR of all done and error bits |

## Verification
The status effects of a command (run, pending, reject and the cleared bits) are due one clock after the edge that takes the command. The bench drives each command for one cycle from a falling edge and reads status at the next falling edge. Completion, promotion and abort happen on a scheduler visit, whose cycle depends on burst and slot history. For these results the bench polls the status bits over a bounded window and then checks memory and the sticky bits. Burst length and interleaving are measured by counting consecutive write strobes, and the cycles of the first and last writes per destination region, at each falling edge.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

  typedef enum logic [2:0] {
    OP_ENABLE   = 3'd0,
    OP_STOP     = 3'd1,
    OP_SET_FAIL = 3'd2,
    OP_SET_SKIP = 3'd3,
    OP_CLEAR    = 3'd4
  } dbdma_op_e;

  typedef enum logic {
    SCH_VISIT = 1'b0,
    SCH_COPY  = 1'b1
  } dbdma_sch_e;

endpackage

// File: rtl/dbdma_rst_sync.sv
module dbdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 11,
  parameter int FAIL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [AW-1:0]     prog_src,
  input  logic [AW-1:0]     prog_dst,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic              cmd_en,
  input  dbdma_op_e         cmd_op,
  input  logic [FAIL_W-1:0] cmd_arg,
  input  logic              visit,
  input  logic              beat,
  output logic              run,
  output logic              pend,
  output logic              done,
  output logic              err,
  output logic              reject,
  output logic              go,
  output logic [AW-1:0]     act_src,
  output logic [AW-1:0]     act_dst,
  output logic [CNT_W-1:0]  act_cnt
);
  localparam logic [AW-1:0]     WORD_BYTES = AW'(4);
  localparam logic [FAIL_W-1:0] FAIL_ONE   = FAIL_W'(1);

  // programming (shadow) set
  logic [AW-1:0]    p_src_q, p_dst_q;
  logic [CNT_W-1:0] p_cnt_q;
  // active set
  logic [AW-1:0]    a_src_q, a_dst_q, a_src_n, a_dst_n;
  logic [CNT_W-1:0] a_cnt_q, a_cnt_n;
  logic             a_en, load_act;
  // control and status
  logic              run_q, pend_q, done_q, err_q, rej_q, skip_q;
  logic              run_n, pend_n, done_n, err_n, rej_n, skip_n;
  logic [FAIL_W-1:0] fail_q, fail_n;
  logic              fail_hit;

  assign fail_hit = (fail_q == FAIL_ONE);

  always_comb begin
    run_n    = run_q;
    pend_n   = pend_q;
    done_n   = done_q;
    err_n    = err_q;
    rej_n    = rej_q;
    skip_n   = skip_q;
    fail_n   = fail_q;
    load_act = 1'b0;

    // clear first so that an event in the same cycle wins
    if (cmd_en && cmd_op == OP_CLEAR) begin
      done_n = 1'b0;
      err_n  = 1'b0;
      rej_n  = 1'b0;
    end

    // scheduler visit
    if (visit && run_q) begin
      if (fail_q != '0) fail_n = fail_q - 1'b1;
      if (fail_hit) begin
        run_n  = 1'b0;
        pend_n = 1'b0;
        err_n  = 1'b1;
      end else if (a_cnt_q == '0) begin
        if (pend_q) begin
          load_act = 1'b1;
          pend_n   = 1'b0;
        end else begin
          run_n = 1'b0;
        end
        if (skip_q) skip_n = 1'b0;
        else        done_n = 1'b1;
      end
    end

    // commands act on the post-visit state
    if (cmd_en) begin
      case (cmd_op)
        OP_ENABLE: begin
          if (run_n) pend_n = 1'b1;
          else begin
            run_n    = 1'b1;
            load_act = 1'b1;
          end
        end
        OP_STOP: begin
          run_n  = 1'b0;
          pend_n = 1'b0;
        end
        OP_SET_FAIL: begin
          if (run_q) rej_n = 1'b1;
          else       fail_n = cmd_arg;
        end
        OP_SET_SKIP: begin
          if (run_q || cmd_arg > FAIL_ONE) rej_n = 1'b1;
          else                             skip_n = cmd_arg[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    a_src_n = a_src_q;
    a_dst_n = a_dst_q;
    a_cnt_n = a_cnt_q;
    if (load_act) begin
      a_src_n = p_src_q;
      a_dst_n = p_dst_q;
      a_cnt_n = p_cnt_q;
    end else if (beat) begin
      a_src_n = a_src_q + WORD_BYTES;
      a_dst_n = a_dst_q + WORD_BYTES;
      a_cnt_n = a_cnt_q - 1'b1;
    end
  end

  assign a_en = load_act | beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_src_q <= '0;
      p_dst_q <= '0;
      p_cnt_q <= '0;
    end else if (prog_we) begin
      p_src_q <= prog_src;
      p_dst_q <= prog_dst;
      p_cnt_q <= prog_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_src_q <= '0;
      a_dst_q <= '0;
      a_cnt_q <= '0;
    end else if (a_en) begin
      a_src_q <= a_src_n;
      a_dst_q <= a_dst_n;
      a_cnt_q <= a_cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
      skip_q <= 1'b0;
      fail_q <= '0;
    end else begin
      run_q  <= run_n;
      pend_q <= pend_n;
      done_q <= done_n;
      err_q  <= err_n;
      rej_q  <= rej_n;
      skip_q <= skip_n;
      fail_q <= fail_n;
    end
  end

  assign go      = run_q && !fail_hit && (a_cnt_q != '0);
  assign run     = run_q;
  assign pend    = pend_q;
  assign done    = done_q;
  assign err     = err_q;
  assign reject  = rej_q;
  assign act_src = a_src_q;
  assign act_dst = a_dst_q;
  assign act_cnt = a_cnt_q;
endmodule

// File: rtl/dbdma_sched.sv
module dbdma_sched
  import dbdma_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CNT_W       = 11,
  parameter int BURST_WORDS = 512
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NCH-1:0]                       go,
  input  logic [NCH-1:0]                       run,
  input  logic [CNT_W-1:0]                     cur_cnt,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] slot,
  output logic [NCH-1:0]                       visit,
  output logic [NCH-1:0]                       beat
);
  localparam int               CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int               LEFT_W  = $clog2(BURST_WORDS + 1);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_WORDS);

  dbdma_sch_e        state_q, state_n;
  logic [CH_W-1:0]   slot_q, slot_n, slot_inc;
  logic [LEFT_W-1:0] left_q, left_n;
  logic              left_en;

  assign slot_inc = (slot_q == CH_W'(NCH - 1)) ? '0 : slot_q + 1'b1;

  always_comb begin
    state_n = state_q;
    slot_n  = slot_q;
    left_n  = left_q;
    left_en = 1'b0;
    visit   = '0;
    beat    = '0;
    case (state_q)
      SCH_VISIT: begin
        visit[slot_q] = 1'b1;
        if (go[slot_q]) begin
          state_n = SCH_COPY;
          left_en = 1'b1;
          left_n  = (cur_cnt > BURST_C) ? LEFT_W'(BURST_WORDS) : LEFT_W'(cur_cnt);
        end else begin
          slot_n = slot_inc;
        end
      end
      default: begin
        if (run[slot_q]) begin
          beat[slot_q] = 1'b1;
          left_en      = 1'b1;
          left_n       = left_q - 1'b1;
          if (left_q == LEFT_W'(1)) begin
            state_n = SCH_VISIT;
            slot_n  = slot_inc;
          end
        end else begin
          state_n = SCH_VISIT;
          slot_n  = slot_inc;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_VISIT;
      slot_q  <= '0;
    end else begin
      state_q <= state_n;
      slot_q  <= slot_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_n;
  end

  assign slot = slot_q;
endmodule

// File: rtl/dbdma_ctrl.sv
module dbdma_ctrl
  import dbdma_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int AW          = 32,
  parameter int CNT_W       = 11,
  parameter int FAIL_W      = 4,
  parameter int BURST_WORDS = 512
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 prog_we,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] prog_ch,
  input  logic [AW-1:0]                        prog_src,
  input  logic [AW-1:0]                        prog_dst,
  input  logic [CNT_W-1:0]                     prog_cnt,
  input  logic                                 cmd_valid,
  input  logic [2:0]                           cmd_op,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cmd_ch,
  input  logic [FAIL_W-1:0]                    cmd_arg,
  output logic [AW-1:0]                        mem_rd_addr,
  input  logic [31:0]                          mem_rd_data,
  output logic                                 mem_wr_en,
  output logic [AW-1:0]                        mem_wr_addr,
  output logic [31:0]                          mem_wr_data,
  output logic [NCH-1:0]                       stat_run,
  output logic [NCH-1:0]                       stat_pend,
  output logic [NCH-1:0]                       stat_done,
  output logic [NCH-1:0]                       stat_err,
  output logic [NCH-1:0]                       stat_reject,
  output logic                                 irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic             rst_sync_n;
  logic [NCH-1:0]   go, visit, beat;
  logic [CH_W-1:0]  slot;
  logic [AW-1:0]    src_arr [NCH];
  logic [AW-1:0]    dst_arr [NCH];
  logic [CNT_W-1:0] cnt_arr [NCH];
  dbdma_op_e        op;

  assign op = dbdma_op_e'(cmd_op);

  dbdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dbdma_chan #(
      .AW     (AW),
      .CNT_W  (CNT_W),
      .FAIL_W (FAIL_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .prog_we  (prog_we && (prog_ch == CH_W'(g))),
      .prog_src (prog_src),
      .prog_dst (prog_dst),
      .prog_cnt (prog_cnt),
      .cmd_en   (cmd_valid && (cmd_ch == CH_W'(g))),
      .cmd_op   (op),
      .cmd_arg  (cmd_arg),
      .visit    (visit[g]),
      .beat     (beat[g]),
      .run      (stat_run[g]),
      .pend     (stat_pend[g]),
      .done     (stat_done[g]),
      .err      (stat_err[g]),
      .reject   (stat_reject[g]),
      .go       (go[g]),
      .act_src  (src_arr[g]),
      .act_dst  (dst_arr[g]),
      .act_cnt  (cnt_arr[g])
    );
  end

  dbdma_sched #(
    .NCH         (NCH),
    .CNT_W       (CNT_W),
    .BURST_WORDS (BURST_WORDS)
  ) u_sched (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .go      (go),
    .run     (stat_run),
    .cur_cnt (cnt_arr[slot]),
    .slot    (slot),
    .visit   (visit),
    .beat    (beat)
  );

  assign mem_rd_addr = src_arr[slot];
  assign mem_wr_addr = dst_arr[slot];
  assign mem_wr_data = mem_rd_data;
  assign mem_wr_en   = |beat;
  assign irq         = |(stat_done | stat_err);
endmodule

// File: rtl/dbdma_ctrl_chk.sv
module dbdma_ctrl_chk
  import dbdma_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int BURST_WORDS = 512
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 cmd_valid,
  input logic [2:0]                           cmd_op,
  input logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cmd_ch,
  input logic                                 mem_wr_en,
  input logic [NCH-1:0]                       run,
  input logic [NCH-1:0]                       pend,
  input logic [NCH-1:0]                       done,
  input logic [NCH-1:0]                       reject
);
  logic [15:0] streak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         streak_q <= '0;
    else if (mem_wr_en) streak_q <= streak_q + 1'b1;
    else                streak_q <= '0;
  end

  // R10
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (streak_q < 16'(BURST_WORDS)));

  // R10
  write_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (run != '0));

  // R2
  enable_idle_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ENABLE && !run[cmd_ch]) |=> run[$past(cmd_ch)]);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STOP) |=> (!run[$past(cmd_ch)] && !pend[$past(cmd_ch)]));

  // R7
  busy_cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_SET_FAIL || cmd_op == OP_SET_SKIP) && run[cmd_ch])
      |=> reject[$past(cmd_ch)]);

  for (genvar i = 0; i < NCH; i++) begin : g_per_ch
    // R3
    pend_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |-> run[i]);

    // R5
    done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> $past(run[i]));
  end
endmodule

bind dbdma_ctrl dbdma_ctrl_chk #(
  .NCH         (NCH),
  .BURST_WORDS (BURST_WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ch    (cmd_ch),
  .mem_wr_en (mem_wr_en),
  .run       (stat_run),
  .pend      (stat_pend),
  .done      (stat_done),
  .reject    (stat_reject)
);

// File: tb/dbdma_ctrl_test.sv
module dbdma_ctrl_test;
  localparam int NCH = 4;
  localparam int AW = 32;
  localparam int CNT_W = 11;
  localparam int FAIL_W = 4;
  localparam int BURST = 4;

  localparam logic [2:0] C_EN = 3'd0, C_STOP = 3'd1, C_FAIL = 3'd2, C_SKIP = 3'd3, C_CLR = 3'd4;

  // {channel, source word, destination word, count}
  localparam logic [31:0] VEC [4] = '{
    {8'd0, 8'd0,  8'd100, 8'd5},
    {8'd1, 8'd10, 8'd120, 8'd4},
    {8'd2, 8'd20, 8'd140, 8'd9},
    {8'd3, 8'd40, 8'd160, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [1:0] prog_ch = '0;
  logic [AW-1:0] prog_src = '0, prog_dst = '0;
  logic [CNT_W-1:0] prog_cnt = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_ch = '0;
  logic [FAIL_W-1:0] cmd_arg = '0;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic mem_wr_en, irq;
  logic [NCH-1:0] stat_run, stat_pend, stat_done, stat_err, stat_reject;

  logic [31:0] mem [256];
  int nchk = 0, nfail = 0;
  int cyc = 0, wr_total = 0, streak = 0, max_streak = 0;
  int last0 = -1, first1 = -1;

  always #10 clk = ~clk;

  dbdma_ctrl #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W), .FAIL_W(FAIL_W), .BURST_WORDS(BURST)) uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_ch(prog_ch), .prog_src(prog_src),
    .prog_dst(prog_dst), .prog_cnt(prog_cnt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_arg(cmd_arg), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .stat_run(stat_run), .stat_pend(stat_pend), .stat_done(stat_done), .stat_err(stat_err),
    .stat_reject(stat_reject), .irq(irq));

  assign mem_rd_data = mem[mem_rd_addr[9:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr[9:2]] <= mem_wr_data;

  // write monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (mem_wr_en) begin
      int idx;
      idx = int'(mem_wr_addr[9:2]);
      wr_total++;
      streak++;
      if (streak > max_streak) max_streak = streak;
      if (idx >= 100 && idx < 112) last0 = cyc;
      if (idx >= 140 && idx < 152 && first1 < 0) first1 = cyc;
    end else streak = 0;
  end

  function automatic logic [31:0] pat(input int i);
    return {8'hA5, 8'(i), 16'(i * 7 + 1)};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic prog(input int ch, input int sw, input int dw, input int n);
    prog_we = 1'b1; prog_ch = 2'(ch);
    prog_src = AW'(sw * 4); prog_dst = AW'(dw * 4); prog_cnt = CNT_W'(n);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input int ch, input int arg);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = 2'(ch); cmd_arg = FAIL_W'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req, input int ch);
    int n = 0;
    while (stat_run[ch] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(stat_run[ch]), 32'd0);
  endtask

  // counts mismatching words of a copy; one check per call
  task automatic chk_copy(input string req, input int sw, input int dw, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (mem[dw + k] !== pat(sw + k)) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", {stat_run, stat_pend, stat_done, stat_err, stat_reject}, 32'd0);
    chk("R1 irq/wr", {30'd0, irq, mem_wr_en}, 32'd0);

    // table walk: R2, R5, R12
    for (int v = 0; v < 4; v++) begin
      int ch, sw, dw, n;
      ch = int'(VEC[v][31:24]); sw = int'(VEC[v][23:16]);
      dw = int'(VEC[v][15:8]);  n  = int'(VEC[v][7:0]);
      init_mem();
      wr_total = 0;
      prog(ch, sw, dw, n);
      cmd(C_EN, ch, 0);
      chk("R2 run after enable", {stat_run[ch], stat_pend[ch]}, 32'd2);
      wait_idle("R5 idle", ch);
      chk_copy("R2 data", sw, dw, n);
      chk("R12 word past end untouched", mem[dw + n], pat(dw + n));
      chk("R12 write count", 32'(wr_total), 32'(n));
      chk("R5 done and irq", {stat_done[ch], irq}, 32'd3);
      cmd(C_CLR, ch, 0);
      chk("R11 clear", {stat_done[ch], stat_err[ch], irq}, 32'd0);
    end

    // R3 / R4 queued transfer promoted without a gap
    init_mem();
    prog(0, 0, 100, 6);
    cmd(C_EN, 0, 0);
    prog(0, 20, 140, 5);
    cmd(C_EN, 0, 0);
    chk("R3 pending while running", {stat_run[0], stat_pend[0]}, 32'd3);
    begin
      int n = 0;
      while (stat_pend[0] && n < 3000) begin @(negedge clk); n++; end
    end
    chk("R4 run held at promotion", {stat_run[0], stat_pend[0]}, 32'd2);
    wait_idle("R4 idle", 0);
    chk_copy("R4 first set", 0, 100, 6);
    chk_copy("R4 queued set", 20, 140, 5);
    chk("R4 done", 32'(stat_done[0]), 32'd1);
    cmd(C_CLR, 0, 0);

    // R10 burst length and round-robin interleave
    init_mem();
    max_streak = 0; last0 = -1; first1 = -1;
    prog(0, 0, 100, 12);
    prog(1, 20, 140, 12);
    cmd(C_EN, 0, 0);
    cmd(C_EN, 1, 0);
    wait_idle("R10 ch0 idle", 0);
    wait_idle("R10 ch1 idle", 1);
    chk("R10 longest burst", 32'(max_streak), 32'(BURST));
    chk("R10 interleave", 32'(first1 > 0 && first1 < last0), 32'd1);
    chk_copy("R10 ch0 data", 0, 100, 12);
    chk_copy("R10 ch1 data", 20, 140, 12);
    cmd(C_CLR, 0, 0);
    cmd(C_CLR, 1, 0);

    // R6 skip one completion, then normal completion
    init_mem();
    cmd(C_SKIP, 1, 1);
    chk("R6 skip accepted", 32'(stat_reject[1]), 32'd0);
    prog(1, 10, 120, 3);
    cmd(C_EN, 1, 0);
    wait_idle("R6 idle", 1);
    chk_copy("R6 data", 10, 120, 3);
    chk("R6 completion hidden", {stat_done[1], irq}, 32'd0);
    cmd(C_EN, 1, 0);
    wait_idle("R6 idle 2", 1);
    chk("R6 next completion seen", 32'(stat_done[1]), 32'd1);
    cmd(C_SKIP, 1, 2);
    chk("R6 skip 2 refused", 32'(stat_reject[1]), 32'd1);
    cmd(C_CLR, 1, 0);
    chk("R11 clear reject", {stat_done[1], stat_reject[1]}, 32'd0);

    // R7 setup while running is ignored
    init_mem();
    prog(3, 40, 160, 20);
    cmd(C_EN, 3, 0);
    cmd(C_FAIL, 3, 1);
    chk("R7 reject while running", 32'(stat_reject[3]), 32'd1);
    wait_idle("R7 idle", 3);
    chk("R7 fault ignored", {stat_done[3], stat_err[3]}, 32'd2);
    chk_copy("R7 data", 40, 160, 20);
    cmd(C_CLR, 3, 0);

    // R9 fault on first visit: nothing written
    init_mem();
    cmd(C_FAIL, 2, 1);
    prog(2, 40, 180, 8);
    cmd(C_EN, 2, 0);
    wait_idle("R9 idle", 2);
    chk("R9 err first visit", {stat_err[2], stat_done[2], stat_pend[2]}, 32'd4);
    chk("R9 no write", mem[180], pat(180));
    cmd(C_CLR, 2, 0);

    // R9 fault on second visit: one burst written
    init_mem();
    cmd(C_FAIL, 2, 2);
    cmd(C_EN, 2, 0);
    wait_idle("R9 idle 2", 2);
    chk("R9 err second visit", {stat_err[2], stat_done[2]}, 32'd2);
    chk_copy("R9 first burst", 40, 180, BURST);
    chk("R9 rest untouched", mem[180 + BURST], pat(180 + BURST));
    cmd(C_CLR, 2, 0);
    chk("R11 clear err", {stat_err[2], irq}, 32'd0);

    // R8 stop mid-transfer with a queued set
    init_mem();
    prog(0, 0, 100, 40);
    cmd(C_EN, 0, 0);
    cmd(C_EN, 0, 0);
    repeat (4) @(negedge clk);
    cmd(C_STOP, 0, 0);
    chk("R8 stop clears", {stat_run[0], stat_pend[0]}, 32'd0);
    begin
      int w0;
      w0 = wr_total;
      repeat (40) @(negedge clk);
      chk("R8 no writes after stop", 32'(wr_total - w0), 32'd0);
    end
    chk("R8 no done", 32'(stat_done[0]), 32'd0);

    summary();
    $finish;
  end
endmodule